// File: doc/BRIEF.md
# Per-Port Statistics Counter Snapshot Unit

This unit keeps 33 event counters for each of six switch ports. A host reaches them over a 16-bit register bus with a snapshot-then-read scheme. Writing the first word address of a counter starts a snapshot of that counter, and the write data is ignored. The status bit then stays busy for a fixed number of cycles. When busy drops, a 64-bit copy of the counter's value at that moment can be read back as 16-bit words.

The counters sit in two address banks. The first bank starts at 0x1000 with 0x40 words per port. The second starts at 0x1180 with 8 words per port. Counters are incremented by one-cycle event strobes, one strobe line per counter. Each counter stops at its full width instead of wrapping.

A control/status word at 0x11F0 shows busy and clear-in-progress. Writing it starts a clear of all counters or of the counters of selected ports. The clear bits drop by themselves once the clear has finished.

Top module: `stat_snap_unit`

## Requirements
- R1: After reset, the control word at 0x11F0 reads 0 and every counter word reads 0.
- R2: Counter c of port p in the first bank (c = 0..28) has its base word at 0x1000 + 0x40*p + off. The offset off is 4*c for c < 2, 8 + 2*(c-2) for c = 2..19, 44 for c = 20, and 48 + 2*(c-21) for c = 21..28.
- R3: Counter c of port p in the second bank (c = 29..32) has its base word at 0x1180 + 8*p + 2*(c-29).
- R4: Counters 0, 1 and 20 span four words and all others span two. A write to a counter's base word, with any data, starts a snapshot, while a write to any other word of a counter does not. The lowest word address returns the least-significant 16 bits, and words above the counter's width read 0.
- R5: A snapshot write sets bit 0 of the control word for BUSY_CYCLES cycles. Word reads during that time return the previous snapshot. Once busy drops, the reads return the counter value at the end of the window.
- R6: A snapshot write made while busy is set is ignored.
- R7: Each strobe cycle adds one to its counter. A counter holds at its maximum (2^NARROW_W-1 for two-word counters, 2^WIDE_W-1 for four-word counters) instead of wrapping.
- R8: Writing 1 to bit 2 of the control word clears every counter. Bits 1 and 2 then read 1 for CLR_CYCLES cycles and drop by themselves, and strobes during that time have no effect.
- R9: Writing 1 to bit 3+p clears only the counters of port p. That bit and bit 1 read 1 until the clear ends, and the other ports keep their counts.
- R10: A read of an address that is neither a counter word nor the control word returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_strobe | input | NUM_PORTS*33 | Event strobes; bit p*33+c advances counter c of port p |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears on bus_rdata after the next edge |
| bus_addr | input | 16 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |

## Verification
The assertions assume that the bus carries single-cycle read and write strobes. They also assume that no snapshot is expected to reflect strobes arriving inside its own busy window. The bench therefore keeps every strobe low while a snapshot is pending or being read back, so each expected value is the arithmetic sum of the pulses given so far, limited by the counter's width. Strobes are raised during a clear on purpose, to show that they are swallowed. The bench uses narrow counter widths so that the saturation limits can be reached within the run.

// File: rtl/stat_snap_pkg.sv
// Shared definitions for the statistics snapshot unit: counter count,
// width class of each counter, and the bus address decoder.
// Assumes at most six ports, since the first bank must end below 0x1180.
package stat_snap_pkg;

    localparam int NUM_CNT   = 33;
    localparam int BANK0_CNT = 29;
    localparam logic [15:0] CTRL_ADDR = 16'h11F0;

    typedef struct packed {
        logic       hit;    // address is a word of an existing counter
        logic [2:0] port;
        logic [5:0] idx;    // counter number within the port
        logic [1:0] word;   // word offset inside the counter
    } loc_t;

    // True for the counters that span four words.
    function automatic bit is_wide(int c);
        return (c == 0) || (c == 1) || (c == 20);
    endfunction

    // Map a bus address onto port, counter and word.
    function automatic loc_t decode(logic [15:0] a, int np);
        loc_t r;
        logic [5:0] off;
        r   = '0;
        off = a[5:0];
        if (a[15:9] == 7'b0001000 && a[8:7] != 2'b11) begin
            r.port = a[8:6];
            if (off < 6'd8) begin
                r.idx  = {5'd0, off[2]};
                r.word = off[1:0];
            end else if (off < 6'd44) begin
                r.idx  = 6'd2 + ((off - 6'd8) >> 1);
                r.word = {1'b0, off[0]};
            end else if (off < 6'd48) begin
                r.idx  = 6'd20;
                r.word = off[1:0];
            end else begin
                r.idx  = 6'd21 + ((off - 6'd48) >> 1);
                r.word = {1'b0, off[0]};
            end
            r.hit = int'(r.port) < np;
        end else if (a[15:6] == 10'b0001000110) begin
            r.port = a[5:3];
            r.idx  = 6'd29 + {4'd0, a[2:1]};
            r.word = {1'b0, a[0]};
            r.hit  = int'(r.port) < np;
        end
        return r;
    endfunction

endpackage

// File: rtl/stat_counter.sv
// One saturating event counter. It advances by one on each inc cycle and
// stops at all-ones. While clr is high it is held at zero, and clr wins
// over inc.
module stat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] q
);

    // Count, saturate or clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                q <= '0;
        else if (clr)              q <= '0;
        else if (inc && q != '1)   q <= q + W'(1);
    end

    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> q == '0);
    assert_sat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q == '1 && !clr) |=> q == '1);
    assert_idle_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(q));

endmodule

// File: rtl/stat_ctrl.sv
// Sequencer for the snapshot busy window and the multi-cycle clear.
// A snapshot request is accepted only while idle. The capture pulse comes
// in the last busy cycle. A clear command is accepted only while no clear
// is running. Its pending bits are held until the clear ends and then drop.
module stat_ctrl #(
    parameter int NP          = 6,
    parameter int BUSY_CYCLES = 4,
    parameter int CLR_CYCLES  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          snap_wr,
    input  logic          ctrl_wr,
    input  logic [15:0]   ctrl_data,
    output logic          snap_start,
    output logic          busy,
    output logic          capture,
    output logic          clearing,
    output logic          glob_pend,
    output logic [NP-1:0] port_pend,
    output logic [NP-1:0] clr_port
);

    localparam int BW = $clog2(BUSY_CYCLES + 1);
    localparam int CW = $clog2(CLR_CYCLES + 1);

    logic [BW-1:0] bcnt;
    logic [CW-1:0] ccnt;
    logic          clr_req;
    logic          unused_data;

    assign busy        = bcnt != '0;
    assign snap_start  = snap_wr && !busy;
    assign capture     = bcnt == BW'(1);
    assign clearing    = ccnt != '0;
    assign clr_req     = ctrl_wr && !clearing && (ctrl_data[2] || (|ctrl_data[3 +: NP]));
    assign clr_port    = {NP{clearing}} & ({NP{glob_pend}} | port_pend);
    assign unused_data = ^{ctrl_data[15:3+NP], ctrl_data[1:0]};

    // Busy window countdown.
    always_ff @(posedge clk) begin
        if (!rst_n)          bcnt <= '0;
        else if (snap_start) bcnt <= BW'(BUSY_CYCLES);
        else if (busy)       bcnt <= bcnt - BW'(1);
    end

    // Clear window countdown with self-clearing command bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ccnt      <= '0;
            glob_pend <= 1'b0;
            port_pend <= '0;
        end else if (clr_req) begin
            ccnt      <= CW'(CLR_CYCLES);
            glob_pend <= ctrl_data[2];
            port_pend <= ctrl_data[3 +: NP];
        end else if (clearing) begin
            ccnt <= ccnt - CW'(1);
            if (ccnt == CW'(1)) begin
                glob_pend <= 1'b0;
                port_pend <= '0;
            end
        end
    end

    assert_busy_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        snap_start |=> busy);
    assert_busy_runs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !capture) |=> busy);
    assert_clear_bits_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clearing |-> (!glob_pend && port_pend == '0));

endmodule

// File: rtl/stat_snap_unit.sv
// Top of the statistics snapshot unit. It holds the per-port counter
// array, decodes the register bus, latches the chosen counter when a
// snapshot is started, and loads the 64-bit copy at the end of the busy
// window. Assumes single-cycle bus strobes and NUM_PORTS between 1 and 6.
module stat_snap_unit
    import stat_snap_pkg::*;
#(
    parameter int NUM_PORTS   = 6,
    parameter int NARROW_W    = 32,
    parameter int WIDE_W      = 64,
    parameter int BUSY_CYCLES = 4,
    parameter int CLR_CYCLES  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_PORTS*NUM_CNT-1:0] ev_strobe,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic [15:0]                  bus_addr,
    input  logic [15:0]                  bus_wdata,
    output logic [15:0]                  bus_rdata
);

    localparam int TOTAL = NUM_PORTS * NUM_CNT;
    localparam int SELW  = $clog2(TOTAL);

    loc_t                 loc;
    logic                 ctrl_hit;
    logic                 snap_start, busy, capture, clearing, glob_pend;
    logic [NUM_PORTS-1:0] port_pend, clr_port;
    logic [SELW-1:0]      flat_idx, sel_q;
    logic [63:0]          snap_q;
    logic [63:0]          vals [TOTAL];

    assign loc      = decode(bus_addr, NUM_PORTS);
    assign ctrl_hit = bus_addr == CTRL_ADDR;
    assign flat_idx = SELW'(loc.port) * SELW'(NUM_CNT) + SELW'(loc.idx);

    stat_ctrl #(
        .NP          (NUM_PORTS),
        .BUSY_CYCLES (BUSY_CYCLES),
        .CLR_CYCLES  (CLR_CYCLES)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .snap_wr    (bus_wr && loc.hit && loc.word == 2'd0),
        .ctrl_wr    (bus_wr && ctrl_hit),
        .ctrl_data  (bus_wdata),
        .snap_start (snap_start),
        .busy       (busy),
        .capture    (capture),
        .clearing   (clearing),
        .glob_pend  (glob_pend),
        .port_pend  (port_pend),
        .clr_port   (clr_port)
    );

    // Counter array: one counter per port and event, width by class.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
            localparam int W = is_wide(c) ? WIDE_W : NARROW_W;
            logic [W-1:0] q;
            stat_counter #(.W(W)) cnt_i (
                .clk   (clk),
                .rst_n (rst_n),
                .inc   (ev_strobe[p*NUM_CNT + c]),
                .clr   (clr_port[p]),
                .q     (q)
            );
            assign vals[p*NUM_CNT + c] = 64'(q);
        end
    end

    // Remember which counter the accepted snapshot write named.
    always_ff @(posedge clk) begin
        if (!rst_n)          sel_q <= '0;
        else if (snap_start) sel_q <= flat_idx;
    end

    // Load the snapshot copy at the end of the busy window.
    always_ff @(posedge clk) begin
        if (!rst_n)       snap_q <= '0;
        else if (capture) snap_q <= vals[sel_q];
    end

    // Registered read mux: control word, snapshot word or zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            if (ctrl_hit)     bus_rdata <= 16'({port_pend, glob_pend, clearing, busy});
            else if (loc.hit) bus_rdata <= snap_q[{loc.word, 4'b0000} +: 16];
            else              bus_rdata <= '0;
        end
    end

    assert_prev_snapshot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !capture) |=> $stable(snap_q));
    assert_busy_ignores_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(sel_q));
    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !ctrl_hit && !loc.hit) |=> bus_rdata == 16'h0000);

endmodule

// File: tb/stat_snap_unit_tb.sv
// Near-exhaustive bench over all 198 counters with narrow widths.
module stat_snap_unit_tb_top;
    import stat_snap_pkg::*;

    localparam int NP = 6;
    localparam int NW = 8;
    localparam int WW = 10;
    localparam int BC = 3;
    localparam int CC = 4;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic [NP*NUM_CNT-1:0] ev;
    logic                 bus_wr, bus_rd;
    logic [15:0]          bus_addr, bus_wdata, bus_rdata;

    int  runs  = 0;
    int  fails = 0;
    bit  done  = 0;
    longint exp_v [NP][NUM_CNT];

    always #10 clk = ~clk;

    stat_snap_unit #(
        .NUM_PORTS(NP), .NARROW_W(NW), .WIDE_W(WW),
        .BUSY_CYCLES(BC), .CLR_CYCLES(CC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ev_strobe(ev), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic int cbase(int p, int c);
        if (c < 2)   return 'h1000 + 'h40*p + 4*c;
        if (c < 20)  return 'h1000 + 'h40*p + 8 + 2*(c-2);
        if (c == 20) return 'h1000 + 'h40*p + 44;
        if (c < 29)  return 'h1000 + 'h40*p + 48 + 2*(c-21);
        return 'h1180 + 8*p + 2*(c-29);
    endfunction

    function automatic int cwords(int c);
        return (c == 0 || c == 1 || c == 20) ? 4 : 2;
    endfunction

    function automatic longint cmax(int c);
        return (cwords(c) == 4) ? ((64'd1 << WW) - 1) : ((64'd1 << NW) - 1);
    endfunction

    task automatic chk(input string tag, input longint act, input longint expv);
        runs++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        bus_addr = 16'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        bus_addr = 16'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic read_cnt(input int p, input int c, output longint v);
        logic [15:0] d;
        v = 0;
        for (int w = 0; w < cwords(c); w++) begin
            rd(cbase(p, c) + w, d);
            v = v | (longint'(d) << (16*w));
        end
    endtask

    task automatic snap_chk(input int p, input int c, input string tag);
        longint v;
        wr(cbase(p, c), 16'hA5A5);
        repeat (BC) @(negedge clk);
        read_cnt(p, c, v);
        chk(tag, v, exp_v[p][c]);
    endtask

    task automatic check_all(input string tag);
        for (int p = 0; p < NP; p++)
            for (int c = 0; c < NUM_CNT; c++)
                snap_chk(p, c, tag);
    endtask

    // Each counter gets a pattern-dependent number of strobe cycles.
    task automatic pulse_all(input int salt);
        for (int t = 0; t < 20; t++) begin
            for (int p = 0; p < NP; p++)
                for (int c = 0; c < NUM_CNT; c++)
                    ev[p*NUM_CNT + c] = (t < ((p*7 + c*3 + salt) % 20) + 1);
            @(negedge clk);
        end
        ev = '0;
        for (int p = 0; p < NP; p++)
            for (int c = 0; c < NUM_CNT; c++) begin
                exp_v[p][c] = exp_v[p][c] + ((p*7 + c*3 + salt) % 20) + 1;
                if (exp_v[p][c] > cmax(c)) exp_v[p][c] = cmax(c);
            end
    endtask

    task automatic pulse_one(input int p, input int c, input int n);
        ev[p*NUM_CNT + c] = 1'b1;
        repeat (n) @(negedge clk);
        ev = '0;
        exp_v[p][c] = exp_v[p][c] + n;
        if (exp_v[p][c] > cmax(c)) exp_v[p][c] = cmax(c);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            runs++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        longint v;
        rst_n = 1'b0; ev = '0; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_addr = '0; bus_wdata = '0;
        for (int p = 0; p < NP; p++)
            for (int c = 0; c < NUM_CNT; c++) exp_v[p][c] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd('h11F0, d); chk("R1 ctrl", longint'(d), 0);
        rd('h1000, d); chk("R1 word", longint'(d), 0);

        // R2 R3 R4 R7: every counter in both banks
        pulse_all(0);
        for (int p = 0; p < NP; p++)
            for (int c = 0; c < NUM_CNT; c++)
                snap_chk(p, c, (c < BANK0_CNT) ? "R2 R4 R7 bank0" : "R3 R4 R7 bank1");

        // R5 R6: busy flag, previous snapshot, ignored second write
        snap_chk(1, 3, "R5 first");
        wr(cbase(4, 7), 16'h0000);
        rd('h11F0, d); chk("R5 busy bit", longint'(d), 1);
        wr(cbase(5, 5), 16'hFFFF);
        rd(cbase(4, 7), d); chk("R5 previous snapshot", longint'(d), exp_v[1][3] & 'hFFFF);
        repeat (BC) @(negedge clk);
        rd('h11F0, d); chk("R5 busy clear", longint'(d), 0);
        read_cnt(4, 7, v); chk("R6 ignored write", v, exp_v[4][7]);

        // R4: a write to a non-base word starts nothing
        wr(cbase(0, 1) + 1, 16'h1234);
        rd('h11F0, d); chk("R4 non-base write", longint'(d), 0);

        // R7: saturation of a wide and a narrow counter
        pulse_one(0, 0, 1100);
        snap_chk(0, 0, "R7 wide saturation");
        pulse_one(2, 5, 300);
        snap_chk(2, 5, "R7 narrow saturation");

        // R8: global clear, strobes swallowed during it
        wr('h11F0, 16'h0004);
        rd('h11F0, d); chk("R8 clear status", longint'(d), 'h6);
        ev[3*NUM_CNT + 3] = 1'b1;
        @(negedge clk);
        ev = '0;
        repeat (CC) @(negedge clk);
        rd('h11F0, d); chk("R8 self clear", longint'(d), 0);
        for (int p = 0; p < NP; p++)
            for (int c = 0; c < NUM_CNT; c++) exp_v[p][c] = 0;
        check_all("R8 all zero");

        // R9: per-port clear of port 2 only
        pulse_all(5);
        wr('h11F0, 16'h0020);
        rd('h11F0, d); chk("R9 clear status", longint'(d), 'h22);
        repeat (CC) @(negedge clk);
        rd('h11F0, d); chk("R9 self clear", longint'(d), 0);
        for (int c = 0; c < NUM_CNT; c++) exp_v[2][c] = 0;
        check_all("R9 port clear");

        // R10: unmapped reads
        rd(cbase(5, 0), d);
        rd('h11C0, d); chk("R10 gap", longint'(d), 0);
        rd('h0FFF, d); chk("R10 low", longint'(d), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

endmodule